// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits between an opcode decoder and an execute stage of an 8-bit processor core. Once the decoder has taken the opcode byte, it pulses `start` with a mode code, the address of the first operand byte, and the current X and Y index values. The unit then reads program and data memory one byte per cycle. It gathers the operand bytes, follows any pointer, and applies any indexing. It finishes with a one-cycle `done` pulse, and holds the effective address, the operand value and the advanced program counter until the next operation.

Memory is read asynchronously. The unit drives `mem_addr` with `mem_rd` high, and `mem_rdata` must hold the byte at that address in the same cycle. Two-byte quantities are little-endian: the lower address holds the low byte. A raw flag asks for the literal operand without pointer following or indexing, which serves a trace or disassembly path. An unsupported mode code ends at once with an error pulse.

The parameter `ZP_WRAP` sets how page-zero arithmetic behaves. With its default of 0, page-zero sums carry into the high byte. With 1, they wrap inside page zero.

Top module: `opnd_ea_gen`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err` and `mem_rd` are low.
- R2: Mode codes 0 and 1 (no operand) issue no read. `done` rises one cycle after `start`, with `ea`=0, `val`=0 and `pc_out`=`pc_in`.
- R3: Mode codes 2 (immediate) and 3 (page zero) read one byte at `pc_in`. `ea` is {0x00, byte}, `val` is the byte and `pc_out` is `pc_in`+1. `done` rises 2 cycles after `start`.
- R4: Mode code 6 (absolute) reads two bytes, low byte first, to form `ea`. `val` is the byte at `ea` and `pc_out` is `pc_in`+2. `done` rises 4 cycles after `start`.
- R5: Mode code 12 (relative) reads one signed offset byte. `ea` is `pc_in`+1+offset, sign-extended, and `val` is the byte at `ea`. `pc_out` is `pc_in`+1 and `done` rises 3 cycles after `start`.
- R6: Mode codes 7 and 8 add X or Y to the 16-bit operand; `pc_out` is `pc_in`+2 and `done` rises after 4 cycles. Mode codes 4 and 5 add X or Y to the one-byte operand, with the carry reaching the high byte when `ZP_WRAP`=0; `pc_out` is `pc_in`+1 and `done` rises after 3 cycles. In all four modes `val` is the byte at `ea`.
- R7: Mode code 9 (indirect) reads a 16-bit pointer. `ea` is the little-endian word at the pointer and pointer+1, and `val` is the byte at `ea`. `pc_out` is `pc_in`+2 and `done` rises 6 cycles after `start`.
- R8: Mode code 10 (pre-indexed indirect) adds X to the page-zero byte. `ea` is the word stored at that sum and the next address, and `val` is the byte at `ea`. `done` rises after 5 cycles.
- R9: Mode code 11 (post-indexed indirect) reads the word at the page-zero byte and the next address, then adds Y to give `ea`. `val` is the byte at `ea` and `done` rises after 5 cycles.
- R10: With `raw` set, no pointer is followed and no index is added. One-byte modes give `ea`={0x00, byte} in 2 cycles. Modes 6, 7, 8 and 9 give `ea` as the 16-bit literal in 3 cycles. Mode 12 gives the branch target in 2 cycles. In every raw case `val` is the low byte of `ea`.
- R11: Mode codes 13 to 15 issue no read. They raise `err` together with `done` one cycle after `start`, with `ea`=0 and `val`=0.
- R12: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own results and timing.
- R13: Exactly one memory read is issued in each busy cycle, so an operation makes (latency − 1) reads. `mem_rd` is never high while idle, and `pc_out` advances by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| raw | input | 1 | Return literal operand, no pointer or index |
| pc_in | input | AW | Address of first operand byte |
| idx_x | input | DW | X index value |
| idx_y | input | DW | Y index value |
| mem_addr | output | AW | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | DW | Memory read data, same cycle |
| ea | output | AW | Effective address |
| val | output | DW | Operand value |
| pc_out | output | AW | Program counter after consumed operand bytes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported mode, pulsed with done |
| busy | output | 1 | Operation in progress |

## Verification
Each operation's `done` is due at a fixed count of clock edges after the edge that takes `start`. That count is one plus the number of bytes the mode must read: 1 edge for no-operand and bad codes, and 2 to 6 edges for the others. Every scenario drives `start` on a falling edge and counts rising edges until `done` is seen at a falling edge. It checks that count against the figure in the requirement, and checks the number of cycles with `mem_rd` high against that figure minus one. The result ports are registered on the edge that raises `done`, so they are compared in that same falling-edge sample.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
   localparam logic [3:0] MD_NONE = 4'd0;
   localparam logic [3:0] MD_ACCU = 4'd1;
   localparam logic [3:0] MD_IMM  = 4'd2;
   localparam logic [3:0] MD_PZ   = 4'd3;
   localparam logic [3:0] MD_PZX  = 4'd4;
   localparam logic [3:0] MD_PZY  = 4'd5;
   localparam logic [3:0] MD_ABS  = 4'd6;
   localparam logic [3:0] MD_ABX  = 4'd7;
   localparam logic [3:0] MD_ABY  = 4'd8;
   localparam logic [3:0] MD_IND  = 4'd9;
   localparam logic [3:0] MD_PXI  = 4'd10;
   localparam logic [3:0] MD_PIY  = 4'd11;
   localparam logic [3:0] MD_REL  = 4'd12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPLO,
      ST_OPHI,
      ST_PTRLO,
      ST_PTRHI,
      ST_DATA
   } seq_state_t;
endpackage

// File: rtl/opnd_pz_add.sv
module opnd_pz_add #(
   parameter int DW   = 8,
   parameter int AW   = 16,
   parameter bit WRAP = 1'b0
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] incr,
   output logic [AW-1:0] sum
);
   localparam int HW = AW - DW;

   generate
      if (WRAP) begin : g_wrap
         logic [DW-1:0] low_sum;
         assign low_sum = base[DW-1:0] + incr;
         assign sum     = {{HW{1'b0}}, low_sum};
      end else begin : g_carry
         assign sum = base + {{HW{1'b0}}, incr};
      end
   endgenerate
endmodule

// File: rtl/opnd_rel_tgt.sv
module opnd_rel_tgt #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic [AW-1:0] pc_at_off,
   input  logic [DW-1:0] offset,
   output logic [AW-1:0] target
);
   localparam int HW = AW - DW;

   logic [AW-1:0] off_ext;
   assign off_ext = {{HW{offset[DW-1]}}, offset};
   assign target  = pc_at_off + AW'(1) + off_ext;
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
   import opnd_ea_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 16,
   parameter bit ZP_WRAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic          raw,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] ea,
   output logic [DW-1:0] val,
   output logic [AW-1:0] pc_out,
   output logic          done,
   output logic          err,
   output logic          busy
);
   localparam int HW = AW - DW;

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("opnd_ea_gen: AW must be twice DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("opnd_ea_gen: DW too small");
      end
   endgenerate

   seq_state_t    st_q;
   logic [3:0]    mode_q;
   logic          raw_q;
   logic [DW-1:0] x_q, y_q, lo_q;
   logic [AW-1:0] pc_q, ptr_q, ea_q;
   logic [DW-1:0] val_q;
   logic          done_q, err_q;

   logic [AW-1:0] pz_idx_sum, pz_nxt_sum, rel_sum, ptr_next, word_in;
   logic [DW-1:0] pz_idx_sel;
   logic          is_pz_ptr;

   assign pz_idx_sel = (mode_q == MD_PZY) ? y_q : x_q;
   assign is_pz_ptr  = (mode_q == MD_PXI) || (mode_q == MD_PIY);
   assign word_in    = {mem_rdata, lo_q};

   opnd_pz_add #(.DW(DW), .AW(AW), .WRAP(ZP_WRAP)) u_pz_idx (
      .base ({{HW{1'b0}}, mem_rdata}),
      .incr (pz_idx_sel),
      .sum  (pz_idx_sum)
   );

   opnd_pz_add #(.DW(DW), .AW(AW), .WRAP(ZP_WRAP)) u_pz_nxt (
      .base (ptr_q),
      .incr (DW'(1)),
      .sum  (pz_nxt_sum)
   );

   opnd_rel_tgt #(.DW(DW), .AW(AW)) u_rel (
      .pc_at_off (pc_q),
      .offset    (mem_rdata),
      .target    (rel_sum)
   );

   assign ptr_next = is_pz_ptr ? pz_nxt_sum : (ptr_q + AW'(1));

   always_comb begin
      mem_addr = '0;
      mem_rd   = 1'b1;
      case (st_q)
         ST_OPLO, ST_OPHI: mem_addr = pc_q;
         ST_PTRLO:         mem_addr = ptr_q;
         ST_PTRHI:         mem_addr = ptr_next;
         ST_DATA:          mem_addr = ea_q;
         default:          mem_rd   = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= '0;
         raw_q  <= 1'b0;
         x_q    <= '0;
         y_q    <= '0;
         lo_q   <= '0;
         pc_q   <= '0;
         ptr_q  <= '0;
         ea_q   <= '0;
         val_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  mode_q <= mode;
                  raw_q  <= raw;
                  x_q    <= idx_x;
                  y_q    <= idx_y;
                  pc_q   <= pc_in;
                  if (mode == MD_NONE || mode == MD_ACCU) begin
                     ea_q   <= '0;
                     val_q  <= '0;
                     done_q <= 1'b1;
                  end else if (mode <= MD_REL) begin
                     st_q <= ST_OPLO;
                  end else begin
                     ea_q   <= '0;
                     val_q  <= '0;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end
               end
            end
            ST_OPLO: begin
               lo_q <= mem_rdata;
               pc_q <= pc_q + AW'(1);
               case (mode_q)
                  MD_ABS, MD_ABX, MD_ABY, MD_IND: st_q <= ST_OPHI;
                  MD_REL: begin
                     ea_q <= rel_sum;
                     if (raw_q) begin
                        val_q  <= rel_sum[DW-1:0];
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else begin
                        st_q <= ST_DATA;
                     end
                  end
                  default: begin
                     if (raw_q || mode_q == MD_IMM || mode_q == MD_PZ) begin
                        ea_q   <= {{HW{1'b0}}, mem_rdata};
                        val_q  <= mem_rdata;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else if (mode_q == MD_PXI) begin
                        ptr_q <= pz_idx_sum;
                        st_q  <= ST_PTRLO;
                     end else if (mode_q == MD_PIY) begin
                        ptr_q <= {{HW{1'b0}}, mem_rdata};
                        st_q  <= ST_PTRLO;
                     end else begin
                        ea_q <= pz_idx_sum;
                        st_q <= ST_DATA;
                     end
                  end
               endcase
            end
            ST_OPHI: begin
               pc_q <= pc_q + AW'(1);
               if (raw_q) begin
                  ea_q   <= word_in;
                  val_q  <= lo_q;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  case (mode_q)
                     MD_ABX:  begin ea_q <= word_in + {{HW{1'b0}}, x_q}; st_q <= ST_DATA; end
                     MD_ABY:  begin ea_q <= word_in + {{HW{1'b0}}, y_q}; st_q <= ST_DATA; end
                     MD_IND:  begin ptr_q <= word_in; st_q <= ST_PTRLO; end
                     default: begin ea_q <= word_in; st_q <= ST_DATA; end
                  endcase
               end
            end
            ST_PTRLO: begin
               lo_q <= mem_rdata;
               st_q <= ST_PTRHI;
            end
            ST_PTRHI: begin
               ea_q <= (mode_q == MD_PIY) ? (word_in + {{HW{1'b0}}, y_q}) : word_in;
               st_q <= ST_DATA;
            end
            ST_DATA: begin
               val_q  <= mem_rdata;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ea     = ea_q;
   assign val    = val_q;
   assign pc_out = pc_q;
   assign done   = done_q;
   assign err    = err_q;
   assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/opnd_ea_gen_chk.sv
module opnd_ea_gen_chk #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [AW-1:0] ea,
   input logic [DW-1:0] val,
   input logic [AW-1:0] pc_out
);
   // R13
   rd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   // R11
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && ea == '0 && val == '0));

   // R13
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R13
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (pc_out == $past(pc_out) || pc_out == $past(pc_out) + AW'(1)));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!done && !err));
endmodule

bind opnd_ea_gen opnd_ea_gen_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mem_rd (mem_rd),
   .busy   (busy),
   .done   (done),
   .err    (err),
   .ea     (ea),
   .val    (val),
   .pc_out (pc_out)
);

// File: tb/opnd_ea_gen_tb_top.sv
module opnd_ea_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic        raw = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  idx_x = '0, idx_y = '0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata;
   logic [15:0] ea, pc_out;
   logic [7:0]  val;
   logic        done, err, busy;

   logic [7:0]  mem [0:4095];
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign mem_rdata = mem[mem_addr[11:0]];

   opnd_ea_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .raw(raw),
      .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .ea(ea), .val(val), .pc_out(pc_out), .done(done), .err(err), .busy(busy)
   );

   function automatic logic [7:0] rd(input logic [15:0] a);
      return mem[a[11:0]];
   endfunction

   task automatic chk(input logic ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] m, input logic r, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y, input int lat,
                         input logic [15:0] eea, input logic [7:0] evl,
                         input logic [15:0] epc, input logic eer, input string tag);
      int got = 0;
      int reads = 0;
      @(negedge clk);
      mode = m; raw = r; pc_in = pc; idx_x = x; idx_y = y; start = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (mem_rd) reads++;
         if (done) begin got = k; break; end
      end
      chk(got == lat, tag, "latency", got, lat);
      chk(reads == lat - 1, tag, "reads", reads, lat - 1);
      chk(ea == eea, tag, "ea", ea, eea);
      chk(val == evl, tag, "val", val, evl);
      chk(pc_out == epc, tag, "pc_out", pc_out, epc);
      chk(err == eer, tag, "err", err, eer);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && !mem_rd, "R1", "idle in reset",
          {busy, done, err, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !mem_rd, "R1", "idle after reset",
          {busy, done, err, mem_rd}, 0);
   endtask

   task automatic t_none;
      run_op(4'd0, 1'b0, 16'h0300, 8'h11, 8'h22, 1, 16'h0, 8'h0, 16'h0300, 1'b0, "R2");
      run_op(4'd1, 1'b0, 16'h0310, 8'h11, 8'h22, 1, 16'h0, 8'h0, 16'h0310, 1'b0, "R2");
   endtask

   task automatic t_imm_pz;
      mem[12'h300] = 8'h9C;
      run_op(4'd2, 1'b0, 16'h0300, 8'h0, 8'h0, 2, 16'h009C, 8'h9C, 16'h0301, 1'b0, "R3");
      run_op(4'd3, 1'b0, 16'h0300, 8'h0, 8'h0, 2, 16'h009C, 8'h9C, 16'h0301, 1'b0, "R3");
   endtask

   task automatic t_abs;
      mem[12'h300] = 8'h34; mem[12'h301] = 8'h02; mem[12'h234] = 8'hA7;
      run_op(4'd6, 1'b0, 16'h0300, 8'h0, 8'h0, 4, 16'h0234, 8'hA7, 16'h0302, 1'b0, "R4");
   endtask

   task automatic t_rel;
      mem[12'h400] = 8'hFB;
      run_op(4'd12, 1'b0, 16'h0400, 8'h0, 8'h0, 3, 16'h03FC, rd(16'h03FC), 16'h0401, 1'b0, "R5");
      mem[12'h400] = 8'h10;
      run_op(4'd12, 1'b0, 16'h0400, 8'h0, 8'h0, 3, 16'h0411, rd(16'h0411), 16'h0401, 1'b0, "R5");
   endtask

   task automatic t_indexed;
      mem[12'h300] = 8'h80; mem[12'h301] = 8'h02;
      run_op(4'd7, 1'b0, 16'h0300, 8'h90, 8'h01, 4, 16'h0310, rd(16'h0310), 16'h0302, 1'b0, "R6");
      run_op(4'd8, 1'b0, 16'h0300, 8'h01, 8'h85, 4, 16'h0305, rd(16'h0305), 16'h0302, 1'b0, "R6");
      mem[12'h300] = 8'hF0;
      run_op(4'd4, 1'b0, 16'h0300, 8'h20, 8'h01, 3, 16'h0110, rd(16'h0110), 16'h0301, 1'b0, "R6");
      run_op(4'd5, 1'b0, 16'h0300, 8'h20, 8'h05, 3, 16'h00F5, rd(16'h00F5), 16'h0301, 1'b0, "R6");
   endtask

   task automatic t_ind;
      mem[12'h300] = 8'h00; mem[12'h301] = 8'h05;
      mem[12'h500] = 8'h22; mem[12'h501] = 8'h07; mem[12'h722] = 8'h5E;
      run_op(4'd9, 1'b0, 16'h0300, 8'h0, 8'h0, 6, 16'h0722, 8'h5E, 16'h0302, 1'b0, "R7");
   endtask

   task automatic t_pxi;
      mem[12'h300] = 8'h40; mem[12'h045] = 8'h10; mem[12'h046] = 8'h06; mem[12'h610] = 8'hC3;
      run_op(4'd10, 1'b0, 16'h0300, 8'h05, 8'h0, 5, 16'h0610, 8'hC3, 16'h0301, 1'b0, "R8");
   endtask

   task automatic t_piy;
      mem[12'h300] = 8'h60; mem[12'h060] = 8'hF0; mem[12'h061] = 8'h05; mem[12'h610] = 8'h3D;
      run_op(4'd11, 1'b0, 16'h0300, 8'h0, 8'h20, 5, 16'h0610, 8'h3D, 16'h0301, 1'b0, "R9");
   endtask

   task automatic t_raw;
      mem[12'h300] = 8'h80; mem[12'h301] = 8'h02;
      run_op(4'd7, 1'b1, 16'h0300, 8'h90, 8'h0, 3, 16'h0280, 8'h80, 16'h0302, 1'b0, "R10");
      mem[12'h300] = 8'h00; mem[12'h301] = 8'h05;
      run_op(4'd9, 1'b1, 16'h0300, 8'h0, 8'h0, 3, 16'h0500, 8'h00, 16'h0302, 1'b0, "R10");
      mem[12'h300] = 8'h60;
      run_op(4'd11, 1'b1, 16'h0300, 8'h0, 8'h20, 2, 16'h0060, 8'h60, 16'h0301, 1'b0, "R10");
      mem[12'h400] = 8'hFB;
      run_op(4'd12, 1'b1, 16'h0400, 8'h0, 8'h0, 2, 16'h03FC, 8'hFC, 16'h0401, 1'b0, "R10");
   endtask

   task automatic t_bad;
      for (int c = 13; c <= 15; c++)
         run_op(4'(c), 1'b0, 16'h0320, 8'h1, 8'h1, 1, 16'h0, 8'h0, 16'h0320, 1'b1, "R11");
   endtask

   task automatic t_busy_start;
      int got = 0;
      mem[12'h300] = 8'h34; mem[12'h301] = 8'h02; mem[12'h234] = 8'hA7;
      @(negedge clk);
      mode = 4'd6; raw = 1'b0; pc_in = 16'h0300; start = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (k == 1) begin mode = 4'd13; pc_in = 16'h0700; start = 1'b1; end
         else start = 1'b0;
         if (done) begin got = k; break; end
      end
      chk(got == 4, "R12", "latency", got, 4);
      chk(ea == 16'h0234 && val == 8'hA7 && !err, "R12", "result", ea, 16'h0234);
      chk(pc_out == 16'h0302, "R12", "pc_out", pc_out, 16'h0302);
      @(negedge clk);
      chk(!done && !busy, "R12", "no extra op", {done, busy}, 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      t_reset();
      t_none();
      t_imm_pz();
      t_abs();
      t_rel();
      t_indexed();
      t_ind();
      t_pxi();
      t_piy();
      t_raw();
      t_bad();
      t_busy_start();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule